// File: doc/BRIEF.md
# SPI Display Frame Loader

This block takes a full grayscale display frame from a host processor over a three-wire SPI link (serial data in, serial clock and an active-low chip select) and stores it in an on-chip frame store. The display refresh logic reads the frame back through a separate read port. Each byte on the wire holds two pixels of 3 bits each, so a pixel has 8 gray levels. The two most significant bits of a byte are expected to be zero. A frame is 3003 bytes long. That is 1001 groups of three bytes, with six pixels in each group.

SCK, the data line and the chip select are sampled in the system clock domain through two-stage synchronisers. Each rising SCK edge is found in that domain. The block counts bits into bytes and counts bytes inside the current chip-select window. Each complete byte is written to the store address equal to its position in the frame. Releasing the chip select throws away any partial byte and restarts the frame at address 0. A one-cycle pulse marks the write of the last byte of the frame. A sticky flag records any byte whose top bits were not zero.

Top module: `spi_frame_loader`

## Requirements
- R1: The data line is sampled on each rising SCK edge while chip select is low (SPI mode 0), most significant bit first. The k-th complete byte after chip select falls, counting from 0, is stored at address k.
- R2: The stored word is 6 bits wide. Its bits 5:3 hold the first pixel of the byte and bits 2:0 hold the second pixel. Bits 7:6 of the received byte are never stored.
- R3: When chip select goes high, the bit count and the byte address are both cleared. A partial byte is discarded and nothing is written for it. The next frame starts at address 0.
- R4: `frameDone` is high for exactly one clock, 3 clocks after the system clock edge at which the SCK rise completing byte 3002 is first sampled. It does not pulse for any other byte.
- R5: `formatError` goes high 3 clocks after the sampled SCK rise that completes a stored byte whose bits 7:6 are not zero. It then stays high until `rstN` is asserted. The byte is still stored, with bits 7:6 removed.
- R6: Bytes that arrive after byte 3002 in the same chip-select window are not stored. They do not set `formatError` and they do not pulse `frameDone`.
- R7: While `rstN` is low, and after it is released with no traffic, `frameDone` and `formatError` are 0.
- R8: `rdData` shows the stored word at `rdAddr` one clock after `rdAddr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock from the host |
| mosi | input | 1 | SPI serial data from the host |
| csN | input | 1 | Active-low chip select from the host |
| rdAddr | input | 12 | Frame store read address |
| rdData | output | 6 | Stored pixel pair, registered |
| frameDone | output | 1 | One-clock pulse when the last frame byte is stored |
| formatError | output | 1 | Sticky flag: a stored byte had nonzero upper bits |

## Verification
The first transfer is a 3-bit partial byte that is dropped when chip select rises. A carried-over bit count would shift every later byte, so this tells a clean restart apart from a misaligned one. A full frame with a position-dependent pattern then checks that each byte lands at its own address, with bit order and pixel packing intact. That frame is followed by extra bytes whose upper bits are set, which shows whether overflow bytes wrap around, are stored, or raise the error flag. A short frame ends in a partial byte and contains one malformed byte. It checks three things: the address restarts, the bytes past the cut keep their old contents, and the error flag sets at the right clock and then holds.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  typedef struct packed {
    logic shiftEn;
    logic writeEn;
    logic clearShift;
  } sfl_strobe_t;
endpackage

// File: rtl/sfl_ctrl.sv
module sfl_ctrl
  import sfl_pkg::*;
#(
  parameter int FRAME_BYTES = 3003,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(FRAME_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              csN,
  output sfl_strobe_t       strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              mosiBit,
  output logic              frameDone
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_BYTES - 1);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(FRAME_BYTES);

  logic [SYNC_STAGES-1:0] sckSync, mosiSync, csSync;
  logic                   sckPrev;
  logic [BIT_W-1:0]       bitCnt;
  logic                   sckRise, csIdle, inFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      csSync   <= '1;
      sckPrev  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sck};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      csSync   <= {csSync[SYNC_STAGES-2:0], csN};
      sckPrev  <= sckSync[SYNC_STAGES-1];
    end
  end

  assign sckRise = sckSync[SYNC_STAGES-1] & ~sckPrev;
  assign csIdle  = csSync[SYNC_STAGES-1];
  assign mosiBit = mosiSync[SYNC_STAGES-1];
  assign inFrame = (wrAddr < END_ADDR);

  always_comb begin
    strb.shiftEn    = sckRise & ~csIdle;
    strb.writeEn    = sckRise & ~csIdle & (bitCnt == LAST_BIT) & inFrame;
    strb.clearShift = csIdle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      wrAddr    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= strb.writeEn && (wrAddr == LAST_ADDR);
      if (csIdle) begin
        bitCnt <= '0;
        wrAddr <= '0;
      end else if (strb.shiftEn) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT && inFrame) wrAddr <= wrAddr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sfl_datapath.sv
module sfl_datapath
  import sfl_pkg::*;
#(
  parameter int FRAME_BYTES = 3003,
  parameter int BYTE_W      = 8,
  parameter int PIX_W       = 3,
  parameter int ADDR_W      = $clog2(FRAME_BYTES + 1),
  parameter int DATA_W      = 2 * PIX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sfl_strobe_t       strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              mosiBit,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              formatError
);
  localparam logic [ADDR_W-1:0] END_ADDR = ADDR_W'(FRAME_BYTES);

  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] fullByte;
  logic              upperBad;
  logic [DATA_W-1:0] store [FRAME_BYTES];

  assign fullByte = {shiftReg, mosiBit};
  assign upperBad = |fullByte[BYTE_W-1:DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      formatError <= 1'b0;
    end else begin
      if (strb.clearShift)   shiftReg <= '0;
      else if (strb.shiftEn) shiftReg <= fullByte[BYTE_W-2:0];
      if (strb.writeEn && upperBad) formatError <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeEn) store[wrAddr] <= fullByte[DATA_W-1:0];
    if (rdAddr < END_ADDR) rdData <= store[rdAddr];
    else                   rdData <= '0;
  end
endmodule

// File: rtl/spi_frame_loader.sv
module spi_frame_loader
  import sfl_pkg::*;
#(
  parameter int FRAME_BYTES = 3003,
  parameter int BYTE_W      = 8,
  parameter int PIX_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(FRAME_BYTES + 1),
  parameter int DATA_W      = 2 * PIX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              mosi,
  input  logic              csN,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              frameDone,
  output logic              formatError
);
  sfl_strobe_t       strb;
  logic [ADDR_W-1:0] wrAddr;
  logic              mosiBit;

  sfl_ctrl #(
    .FRAME_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W),
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .csN(csN),
    .strb(strb), .wrAddr(wrAddr), .mosiBit(mosiBit), .frameDone(frameDone)
  );

  sfl_datapath #(
    .FRAME_BYTES(FRAME_BYTES), .BYTE_W(BYTE_W), .PIX_W(PIX_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .mosiBit(mosiBit),
    .rdAddr(rdAddr), .rdData(rdData), .formatError(formatError)
  );
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker
  import sfl_pkg::*;
#(
  parameter int FRAME_BYTES = 3003,
  parameter int ADDR_W      = $clog2(FRAME_BYTES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input sfl_strobe_t       strb,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              frameDone,
  input logic              formatError
);
  // R4: frameDone never lasts two clocks
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  // R4: frameDone only follows a store strobe
  a_r4_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(strb.writeEn));
  // R5: the error flag is sticky
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    formatError |=> formatError);
  // R6: no store beyond the last frame address
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEn |-> (wrAddr < ADDR_W'(FRAME_BYTES)));
  // R3: a chip select held high clears the address
  a_r3_addr_clear: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN, 1) && $past(csN, 2) && $past(csN, 3)) |-> (wrAddr == '0));
endmodule

bind spi_frame_loader sfl_checker #(.FRAME_BYTES(FRAME_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .strb(strb), .wrAddr(wrAddr),
  .frameDone(frameDone), .formatError(formatError)
);

// File: tb/tb_spi_frame_loader.sv
module tb_spi_frame_loader;
  localparam int NB = 3003;

  logic clk = 0, rstN = 0, sck = 0, mosi = 0, csN = 1;
  logic [11:0] rdAddr = '0;
  logic [5:0]  rdData;
  logic frameDone, formatError;

  int compared = 0, mismatched = 0;
  int cyc = 0;
  int doneAt = -1, errAt = -1;
  int modelAddr = 0;
  int expMem [NB];
  bit monOn = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_frame_loader dut (.clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .csN(csN),
    .rdAddr(rdAddr), .rdData(rdData), .frameDone(frameDone), .formatError(formatError));

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // Per-clock reference comparison of the status outputs (R4, R5, R6, R7)
  always @(negedge clk) if (monOn) begin
    check("R4 frameDone", int'(frameDone), int'(cyc == doneAt));
    check("R5 formatError", int'(formatError), int'(errAt >= 0 && cyc >= errAt));
  end

  // one bit: low phase with data, then rising edge
  task automatic sendBit(input bit b, output int stamp);
    @(negedge clk); sck = 0; mosi = b;
    @(negedge clk); sck = 1; stamp = cyc;
  endtask

  task automatic sendByte(input logic [7:0] v);
    int stamp = 0;
    for (int i = 7; i >= 0; i--) sendBit(v[i], stamp);
    if (modelAddr < NB) begin
      expMem[modelAddr] = int'(v[5:0]);
      if (v[7:6] != 2'b00 && errAt < 0) errAt = stamp + 3;
      if (modelAddr == NB - 1) doneAt = stamp + 3;
      modelAddr++;
    end
  endtask

  task automatic sendBits(input int n);
    int stamp = 0;
    for (int i = 0; i < n; i++) sendBit(1'b1, stamp);
  endtask

  task automatic csLow();
    @(negedge clk); sck = 0; csN = 0; modelAddr = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk); sck = 0; csN = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic readCheck(input string req, input int a);
    @(negedge clk); rdAddr = 12'(a);
    @(negedge clk);
    check(req, int'(rdData), expMem[a]);
  endtask

  function automatic logic [7:0] patA(input int i);
    return 8'((i * 5 + i / 3) & 63);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NB; i++) expMem[i] = 0;
    repeat (3) @(negedge clk);
    check("R7 frameDone in reset", int'(frameDone), 0);
    check("R7 formatError in reset", int'(formatError), 0);
    rstN = 1;
    monOn = 1;
    repeat (4) @(negedge clk);

    // R3: partial byte dropped at chip select release
    csLow(); sendBits(3); csHigh();

    // R1 R2 R6: full frame, then overflow bytes with upper bits set
    csLow();
    for (int i = 0; i < NB; i++) sendByte(patA(i));
    for (int i = 0; i < 4; i++) sendByte(8'hC0 | 8'(i + 9));
    csHigh();
    for (int a = 0; a < NB; a++) readCheck("R1 R2 R6 R8 frame readback", a);

    // R3 R5: short frame with one bad byte, ending in a partial byte
    csLow();
    sendByte(8'h2A); sendByte(8'h15); sendByte(8'h47); sendByte(8'h3F); sendByte(8'h00);
    sendBits(5);
    csHigh();
    for (int a = 0; a < 8; a++) readCheck("R3 R5 restart readback", a);
    readCheck("R6 last address untouched", NB - 1);

    repeat (10) @(negedge clk);
    monOn = 0;
    finishRun();
  end
endmodule